// File: doc/BRIEF.md
# Bidirectional Recirculating Shift Register

A serial shift register with a parameterised number of single-bit stages (default 32, numbered 1 to N). On each rising clock edge every stage takes the value of one neighbour, so the contents move one position toward stage N (right) or toward stage 1 (left), depending on a direction input. A source-select input decides what enters the end stage that opens up. When it is high, the end stage takes an external serial bit. When it is low, it takes the bit that just left the far end, so the contents rotate.

A hold input freezes all stages. Two serial outputs report the two end stages, stage 1 on the left and stage N on the right. Both outputs update only on the falling clock edge, half a cycle after the rising edge that captured the data. This gives master-slave style timing, which lets several instances be chained: one instance's end output connects to the matching serial input of its neighbour. A synchronous active-high clear empties the register and both outputs.

Top module: `bidir_shift_reg`

## Requirements
- R1: While `clr` is high on a rising edge, every stage becomes 0. Both `outLeftEnd` and `outRightEnd` read 0 after the following falling edge. Clear takes priority over hold and shifting.
- R2: With `dirCtl`=0, `loadExt`=1 and `holdEn`=0, a rising edge loads `serInRight` into stage 1, and each stage k>1 takes the old value of stage k-1.
- R3: With `dirCtl`=1, `loadExt`=1 and `holdEn`=0, a rising edge loads `serInLeft` into stage N, and each stage k<N takes the old value of stage k+1.
- R4: With `loadExt`=0 and `holdEn`=0, the contents rotate and both serial inputs have no effect. Old stage N enters stage 1 when `dirCtl`=0, and old stage 1 enters stage N when `dirCtl`=1.
- R5: With `holdEn`=1 and `clr`=0, a rising edge leaves every stage unchanged, whatever the other inputs are.
- R6: `outLeftEnd` shows stage 1 and `outRightEnd` shows stage N. Both change only on a falling edge, so between a rising edge and the next falling edge they still show the values from before that rising edge.
- R7: N consecutive rotations in the same direction return the register to its original contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stages capture on the rising edge, outputs on the falling edge |
| clr | input | 1 | Synchronous active-high clear |
| dirCtl | input | 1 | 0: move toward stage N; 1: move toward stage 1 |
| loadExt | input | 1 | 1: end stage takes external serial bit; 0: rotate |
| holdEn | input | 1 | 1: freeze all stages |
| serInRight | input | 1 | Serial bit entering stage 1 when moving toward stage N |
| serInLeft | input | 1 | Serial bit entering stage N when moving toward stage 1 |
| outLeftEnd | output | 1 | Stage 1 value, updated on the falling edge |
| outRightEnd | output | 1 | Stage N value, updated on the falling edge |

## Verification
The assertions assume that `dirCtl`, `loadExt`, `holdEn` and `clr` are settled before each rising edge and stay fixed through the high phase. The bench keeps to this by changing every input shortly after a falling edge, while the clock is low. The falling-edge output registers sample `clr` directly, so the bench never changes `clr` in the high phase either. The output-timing property compares the ends with the stage vector at each rising edge, which only holds if nothing besides the falling edge moves the outputs.

// File: rtl/shiftreg_pkg.sv
package shiftreg_pkg;
  typedef struct packed {
    logic clear;      // zero the stages and outputs
    logic advance;    // move contents this edge
    logic towardLow;  // 1: toward stage 1, 0: toward stage N
    logic takeExt;    // 1: external serial bit, 0: recirculate
  } stepCtl_t;
endpackage

// File: rtl/shiftreg_ctrl.sv
module shiftreg_ctrl
  import shiftreg_pkg::*;
(
  input  logic     clrIn,
  input  logic     holdIn,
  input  logic     dirIn,
  input  logic     extIn,
  output stepCtl_t strobe
);
  always_comb begin
    strobe.clear     = clrIn;
    strobe.advance   = !clrIn && !holdIn;
    strobe.towardLow = dirIn;
    strobe.takeExt   = extIn;
  end
endmodule

// File: rtl/shiftreg_datapath.sv
module shiftreg_datapath
  import shiftreg_pkg::*;
#(
  parameter int NUM_STAGES = 32
) (
  input  logic                  clk,
  input  stepCtl_t              strobe,
  input  logic                  serInRight,
  input  logic                  serInLeft,
  output logic [NUM_STAGES-1:0] stageVec,
  output logic                  outLeftEnd,
  output logic                  outRightEnd
);
  localparam int LAST = NUM_STAGES - 1;

  logic [NUM_STAGES-1:0] nextVec;
  logic                  feedLow;
  logic                  feedHigh;

  // bits entering the open end stage
  assign feedLow  = strobe.takeExt ? serInRight : stageVec[LAST];
  assign feedHigh = strobe.takeExt ? serInLeft  : stageVec[0];

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
    logic fromBelow;
    logic fromAbove;
    if (i == 0) begin : g_first
      assign fromBelow = feedLow;
    end else begin : g_midLow
      assign fromBelow = stageVec[i-1];
    end
    if (i == LAST) begin : g_last
      assign fromAbove = feedHigh;
    end else begin : g_midHigh
      assign fromAbove = stageVec[i+1];
    end
    assign nextVec[i] = strobe.towardLow ? fromAbove : fromBelow;
  end

  always_ff @(posedge clk) begin
    if (strobe.clear)        stageVec <= '0;
    else if (strobe.advance) stageVec <= nextVec;
  end

  // slave side: ends become visible on the falling edge
  always_ff @(negedge clk) begin
    if (strobe.clear) begin
      outLeftEnd  <= 1'b0;
      outRightEnd <= 1'b0;
    end else begin
      outLeftEnd  <= stageVec[0];
      outRightEnd <= stageVec[LAST];
    end
  end
endmodule

// File: rtl/bidir_shift_reg.sv
module bidir_shift_reg
  import shiftreg_pkg::*;
#(
  parameter int NUM_STAGES = 32
) (
  input  logic clk,
  input  logic clr,
  input  logic dirCtl,
  input  logic loadExt,
  input  logic holdEn,
  input  logic serInRight,
  input  logic serInLeft,
  output logic outLeftEnd,
  output logic outRightEnd
);
  stepCtl_t              strobe;
  logic [NUM_STAGES-1:0] stageVec;

  shiftreg_ctrl u_ctrl (
    .clrIn (clr),
    .holdIn(holdEn),
    .dirIn (dirCtl),
    .extIn (loadExt),
    .strobe(strobe)
  );

  shiftreg_datapath #(.NUM_STAGES(NUM_STAGES)) u_dp (
    .clk        (clk),
    .strobe     (strobe),
    .serInRight (serInRight),
    .serInLeft  (serInLeft),
    .stageVec   (stageVec),
    .outLeftEnd (outLeftEnd),
    .outRightEnd(outRightEnd)
  );
endmodule

// File: rtl/shiftreg_chk.sv
module shiftreg_chk #(
  parameter int NUM_STAGES = 32
) (
  input logic                  clk,
  input logic                  clr,
  input logic                  dirCtl,
  input logic                  loadExt,
  input logic                  holdEn,
  input logic                  serInRight,
  input logic                  serInLeft,
  input logic [NUM_STAGES-1:0] stageVec,
  input logic                  outLeftEnd,
  input logic                  outRightEnd
);
  localparam int LAST = NUM_STAGES - 1;

  // R1
  clear_empties_chk: assert property (@(posedge clk)
    clr |=> (stageVec == '0));

  // R2
  right_shift_chk: assert property (@(posedge clk) disable iff (clr)
    (!holdEn && !dirCtl && loadExt) |=>
      (stageVec[0] == $past(serInRight)) &&
      (stageVec[LAST:1] == $past(stageVec[LAST-1:0])));

  // R3
  left_shift_chk: assert property (@(posedge clk) disable iff (clr)
    (!holdEn && dirCtl && loadExt) |=>
      (stageVec[LAST] == $past(serInLeft)) &&
      (stageVec[LAST-1:0] == $past(stageVec[LAST:1])));

  // R4
  rotate_right_chk: assert property (@(posedge clk) disable iff (clr)
    (!holdEn && !dirCtl && !loadExt) |=>
      (stageVec == {$past(stageVec[LAST-1:0]), $past(stageVec[LAST])}));

  // R4
  rotate_left_chk: assert property (@(posedge clk) disable iff (clr)
    (!holdEn && dirCtl && !loadExt) |=>
      (stageVec == {$past(stageVec[0]), $past(stageVec[LAST:1])}));

  // R5
  hold_freezes_chk: assert property (@(posedge clk) disable iff (clr)
    holdEn |=> $stable(stageVec));

  // R6
  ends_lag_chk: assert property (@(posedge clk) disable iff (clr)
    (outLeftEnd == stageVec[0]) && (outRightEnd == stageVec[LAST]));
endmodule

bind bidir_shift_reg shiftreg_chk #(.NUM_STAGES(NUM_STAGES)) u_chk (
  .clk        (clk),
  .clr        (clr),
  .dirCtl     (dirCtl),
  .loadExt    (loadExt),
  .holdEn     (holdEn),
  .serInRight (serInRight),
  .serInLeft  (serInLeft),
  .stageVec   (stageVec),
  .outLeftEnd (outLeftEnd),
  .outRightEnd(outRightEnd)
);

// File: tb/bidir_shift_reg_tb.sv
module bidir_shift_reg_tb;
  localparam int N = 32;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic clr, dirCtl, loadExt, holdEn, serInRight, serInLeft;
  logic outLeftEnd, outRightEnd;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic model [N];
  logic saved [N];
  logic prevL, prevR;

  always #(CLK_PERIOD/2) clk = ~clk;

  bidir_shift_reg #(.NUM_STAGES(N)) u_dut (
    .clk(clk), .clr(clr), .dirCtl(dirCtl), .loadExt(loadExt), .holdEn(holdEn),
    .serInRight(serInRight), .serInLeft(serInLeft),
    .outLeftEnd(outLeftEnd), .outRightEnd(outRightEnd)
  );

  task automatic check(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: inputs set in low phase, R6 checked on both half cycles
  task automatic step(string req, logic d, logic e, logic h, logic inR, logic inL);
    logic nxt [N];
    dirCtl = d; loadExt = e; holdEn = h; serInRight = inR; serInLeft = inL;
    prevL = outLeftEnd; prevR = outRightEnd;
    @(posedge clk);
    if (!h) begin
      for (int i = 0; i < N; i++) begin
        if (!d) nxt[i] = (i == 0) ? (e ? inR : model[N-1]) : model[i-1];
        else    nxt[i] = (i == N-1) ? (e ? inL : model[0]) : model[i+1];
      end
      for (int i = 0; i < N; i++) model[i] = nxt[i];
    end
    #2;
    check("R6 left held in high phase", outLeftEnd, prevL);
    check("R6 right held in high phase", outRightEnd, prevR);
    @(negedge clk); #1;
    check(req, outLeftEnd, model[0]);
    check(req, outRightEnd, model[N-1]);
  endtask

  task automatic doClear();
    clr = 1'b1; holdEn = 1'b1;
    @(posedge clk); @(negedge clk); #1;
    clr = 1'b0;
    for (int i = 0; i < N; i++) model[i] = 1'b0;
    check("R1 clear left", outLeftEnd, 1'b0);
    check("R1 clear right", outRightEnd, 1'b0);
  endtask

  task automatic testShiftRight();
    for (int k = 0; k < N; k++) step("R2 shift right", 1'b0, 1'b1, 1'b0, ((k % 3) == 0), 1'b1);
  endtask

  task automatic testShiftLeft();
    for (int k = 0; k < N + 4; k++) step("R3 shift left", 1'b1, 1'b1, 1'b0, 1'b1, ((k % 5) < 2));
  endtask

  task automatic testRotate(logic d, string req);
    for (int i = 0; i < N; i++) saved[i] = model[i];
    for (int k = 0; k < N; k++) step(req, d, 1'b0, 1'b0, k[0], ~k[0]);
    for (int i = 0; i < N; i++) begin
      total++;
      if (model[i] !== saved[i]) begin
        bad++;
        $display("FAIL R7 model stage %0d: actual=%b expected=%b", i, model[i], saved[i]);
      end
    end
    check("R7 rotation restores left end", outLeftEnd, saved[0]);
    check("R7 rotation restores right end", outRightEnd, saved[N-1]);
  endtask

  task automatic testHold();
    for (int k = 0; k < 6; k++) step("R5 hold", k[0], k[1], 1'b1, ~k[0], k[1]);
    // reveal the frozen contents through a rotation
    for (int k = 0; k < N; k++) step("R5 contents kept after hold", 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic testClearMidway();
    step("R2 refill", 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    doClear();
    for (int k = 0; k < N; k++) step("R1 empty after clear", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
  endtask

  initial begin
    clr = 1'b1; dirCtl = 1'b0; loadExt = 1'b1; holdEn = 1'b0;
    serInRight = 1'b0; serInLeft = 1'b0;
    @(negedge clk);
    doClear();
    testShiftRight();
    testRotate(1'b0, "R4 rotate right ignores inputs");
    testShiftLeft();
    testRotate(1'b1, "R4 rotate left ignores inputs");
    testHold();
    testClearMidway();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule